// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block is the register-mapped command front end of an SD host controller. Software writes a transfer geometry word (block size and block count), a 32-bit command argument and a command word. The command word carries the command index, the response type, the data-present flag and the transfer-mode bits. When the command path is free, the write is accepted and a one-cycle start pulse goes to the card-side engine, which sits outside this block. The pulse comes with the stored command fields. Only this engine deals with the lines, CRC and data.

The unit keeps two inhibit flags. The command inhibit covers the command path from acceptance until the engine reports completion or an error. The data inhibit covers the data path for commands that move data or signal busy, and stays set until the engine reports data done or busy release. Response words returned by the engine are captured into four response registers, and how many are written depends on the response type. Completion, data events and all error causes are collected in one write-one-to-clear interrupt word, together with a derived summary error bit. A mask register gates that word onto a single interrupt line.

Top module: `sdh_cmd_issue`

## Requirements
- R1: A write to the command word (address 2) that is accepted produces exactly one cycle of `cmd_start`, in the cycle after the write. While `cmd_start` is high, `cmd_index`, `cmd_arg` and `cmd_rsp_type` show the written command bits 29:24, the argument register (address 1) and command bits 17:16.
- R2: While the command inhibit (status bit 0, address 7) is set, a command-word write is ignored: no `cmd_start` pulse follows, and reading address 2 returns the word that was last accepted. An accepted command sets the command inhibit.
- R3: A command with response type 3 (48-bit with busy) is ignored while the data inhibit (status bit 1) is set. A command of any other type is still accepted in that state.
- R4: An accepted command with response type 3 or with the data-present flag (bit 21) set sets the data inhibit. A pulse on `eng_busy_rel` or on `eng_data_done` clears it. Status bit 2 mirrors `eng_dat_active`.
- R5: When `eng_cmd_done` arrives for a command of response type 1 (136-bit), all four response registers (addresses 3 to 6) load `eng_rsp` words 0 to 3.
- R6: When `eng_cmd_done` arrives for response type 2 or 3 (48-bit), only response register 0 loads `eng_rsp[31:0]`. For type 0 (no response), no response register changes.
- R7: Interrupt status (address 8) sets bit 0 on `eng_cmd_done`, bit 1 on `eng_data_done`, bit 4 on `eng_wr_rdy` and bit 5 on `eng_rd_rdy`. Writing 1 to a bit clears it, and a bit written 0 keeps its value.
- R8: Error inputs `eng_err[8:0]` set interrupt status bits 24:16. Bit 15 reads as the OR of bits 24:16, so it drops once every error bit has been cleared. A write to bit 15 alone changes nothing.
- R9: `irq` is high exactly when the interrupt status word ANDed with the mask register (address 9) is nonzero.
- R10: The geometry register (address 0) keeps the block size in bits 9:0 and the block count in bits 31:16, drives them out on `xfer_blk_size` and `xfer_blk_cnt`, and reads bits 15:10 as zero.
- R11: The command inhibit clears after `eng_cmd_done` or after any nonzero `eng_err`.
- R12: After reset, all registers read zero, no inhibit is set and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Masked interrupt request |
| cmd_start | output | 1 | One-cycle command start to the engine |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp_type | output | 2 | Response type, 0 none, 1 136-bit, 2 48-bit, 3 48-bit busy |
| cmd_has_data | output | 1 | Data-present flag |
| cmd_card_to_host | output | 1 | Transfer direction, 1 means card to host |
| cmd_multi_blk | output | 1 | Multi-block flag |
| cmd_cnt_en | output | 1 | Block-count enable |
| xfer_blk_size | output | BLK_SZ_W | Block size |
| xfer_blk_cnt | output | BLK_CNT_W | Block count |
| eng_cmd_done | input | 1 | Engine reports command complete, response valid |
| eng_rsp | input | 128 | Response words from the engine |
| eng_err | input | ERR_BITS | Error cause pulses |
| eng_data_done | input | 1 | Data transfer finished |
| eng_wr_rdy | input | 1 | Write buffer ready event |
| eng_rd_rdy | input | 1 | Read buffer ready event |
| eng_busy_rel | input | 1 | Card has released busy |
| eng_dat_active | input | 1 | Data lines active (level) |

## Verification
Random commands mix all four response types with random indices, arguments and data flags. This separates the 136-bit path, which fills four response registers, from the 48-bit path, which fills one, and from the no-response path, which fills none. Each random command ends either in completion with random response words or in a random nonzero error set, under a random mask. This shows whether the inhibit release, the summary error bit and the masked interrupt line follow each outcome correctly. Directed cases probe a second command while the first is in flight, a busy command against a held data inhibit, a lone write to the summary bit, partial clears of the event bits, and the reserved bits of the geometry register.

// File: rtl/sdh_cmd_pkg.sv
package sdh_cmd_pkg;
   localparam int REG_W       = 32;
   // register word addresses
   localparam int REG_BLK     = 0;
   localparam int REG_ARG     = 1;
   localparam int REG_CMD     = 2;
   localparam int REG_RSP0    = 3;
   localparam int REG_STATUS  = 7;
   localparam int REG_IRQ     = 8;
   localparam int REG_MASK    = 9;
   // command word fields
   localparam int CW_IDX_LSB  = 24;
   localparam int CW_DATA_BIT = 21;
   localparam int CW_RSP_LSB  = 16;
   localparam int CW_MULTI    = 5;
   localparam int CW_DIR      = 4;
   localparam int CW_CNTEN    = 1;
   localparam int BLK_CNT_LSB = 16;
   // interrupt word positions
   localparam int IRQ_CMD_DONE  = 0;
   localparam int IRQ_DATA_DONE = 1;
   localparam int IRQ_WR_RDY    = 4;
   localparam int IRQ_RD_RDY    = 5;
   localparam int IRQ_ERR_SUM   = 15;
   localparam int IRQ_ERR_LSB   = 16;

   typedef enum logic [1:0] {
      RSP_NONE = 2'd0,
      RSP_136  = 2'd1,
      RSP_48   = 2'd2,
      RSP_48B  = 2'd3
   } rsp_e;
endpackage

// File: rtl/sdh_inhibit_track.sv
module sdh_inhibit_track (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_cmd,
   input  logic [1:0] wr_rsp,
   input  logic       wr_data_flag,
   input  logic       eng_cmd_done,
   input  logic       eng_err_any,
   input  logic       eng_busy_rel,
   input  logic       eng_data_done,
   output logic       accept,
   output logic       cmd_inh,
   output logic       dat_inh
);
   import sdh_cmd_pkg::*;

   logic busy_type;

   assign busy_type = (wr_rsp == RSP_48B);
   assign accept    = wr_cmd && !cmd_inh && !(busy_type && dat_inh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_inh <= 1'b0;
         dat_inh <= 1'b0;
      end else begin
         if (accept)
            cmd_inh <= 1'b1;
         else if (eng_cmd_done || eng_err_any)
            cmd_inh <= 1'b0;

         if (accept && (busy_type || wr_data_flag))
            dat_inh <= 1'b1;
         else if (eng_busy_rel || eng_data_done)
            dat_inh <= 1'b0;
      end
   end
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status #(
   parameter int ERR_BITS = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ev_cmd_done,
   input  logic                ev_data_done,
   input  logic                ev_wr_rdy,
   input  logic                ev_rd_rdy,
   input  logic [ERR_BITS-1:0] ev_err,
   input  logic                clr_wr,
   input  logic [3:0]          clr_ev,
   input  logic [ERR_BITS-1:0] clr_err,
   output logic [31:0]         stat_word
);
   import sdh_cmd_pkg::*;

   logic [3:0]          ev_q;
   logic [3:0]          ev_set;
   logic [ERR_BITS-1:0] err_q;

   assign ev_set = {ev_rd_rdy, ev_wr_rdy, ev_data_done, ev_cmd_done};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q  <= '0;
         err_q <= '0;
      end else begin
         ev_q  <= (ev_q  & ~(clr_ev  & {4{clr_wr}}))        | ev_set;
         err_q <= (err_q & ~(clr_err & {ERR_BITS{clr_wr}})) | ev_err;
      end
   end

   always_comb begin
      stat_word                          = '0;
      stat_word[IRQ_CMD_DONE]            = ev_q[0];
      stat_word[IRQ_DATA_DONE]           = ev_q[1];
      stat_word[IRQ_WR_RDY]              = ev_q[2];
      stat_word[IRQ_RD_RDY]              = ev_q[3];
      stat_word[IRQ_ERR_SUM]             = |err_q;
      stat_word[IRQ_ERR_LSB +: ERR_BITS] = err_q;
   end
endmodule

// File: rtl/sdh_rsp_bank.sv
module sdh_rsp_bank #(
   parameter int RSP_REGS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [1:0]             rsp_type,
   input  logic [RSP_REGS*32-1:0] rsp_in,
   output logic [RSP_REGS*32-1:0] rsp_q
);
   import sdh_cmd_pkg::*;

   for (genvar i = 0; i < RSP_REGS; i++) begin : g_word
      logic take;
      if (i == 0) begin : g_first
         assign take = load && (rsp_type != RSP_NONE);
      end else begin : g_rest
         assign take = load && (rsp_type == RSP_136);
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rsp_q[i*32 +: 32] <= '0;
         else if (take)
            rsp_q[i*32 +: 32] <= rsp_in[i*32 +: 32];
      end
   end
endmodule

// File: rtl/sdh_cmd_issue.sv
module sdh_cmd_issue #(
   parameter int ADDR_W    = 4,
   parameter int ERR_BITS  = 9,
   parameter int BLK_SZ_W  = 10,
   parameter int BLK_CNT_W = 16,
   parameter int RSP_REGS  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr_en,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [31:0]            bus_wdata,
   output logic [31:0]            bus_rdata,
   output logic                   irq,
   output logic                   cmd_start,
   output logic [5:0]             cmd_index,
   output logic [31:0]            cmd_arg,
   output logic [1:0]             cmd_rsp_type,
   output logic                   cmd_has_data,
   output logic                   cmd_card_to_host,
   output logic                   cmd_multi_blk,
   output logic                   cmd_cnt_en,
   output logic [BLK_SZ_W-1:0]    xfer_blk_size,
   output logic [BLK_CNT_W-1:0]   xfer_blk_cnt,
   input  logic                   eng_cmd_done,
   input  logic [RSP_REGS*32-1:0] eng_rsp,
   input  logic [ERR_BITS-1:0]    eng_err,
   input  logic                   eng_data_done,
   input  logic                   eng_wr_rdy,
   input  logic                   eng_rd_rdy,
   input  logic                   eng_busy_rel,
   input  logic                   eng_dat_active
);
   import sdh_cmd_pkg::*;

   localparam logic [ADDR_W-1:0] A_BLK    = ADDR_W'(REG_BLK);
   localparam logic [ADDR_W-1:0] A_ARG    = ADDR_W'(REG_ARG);
   localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(REG_CMD);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
   localparam logic [ADDR_W-1:0] A_IRQ    = ADDR_W'(REG_IRQ);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(REG_MASK);

   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must cover the register map");
   end
   if (ERR_BITS < 1 || ERR_BITS > 16) begin : g_bad_err
      $error("ERR_BITS must be in 1..16");
   end
   if (BLK_SZ_W > 16 || BLK_CNT_W > 16) begin : g_bad_blk
      $error("block fields must fit their half words");
   end
   if (RSP_REGS != 4) begin : g_bad_rsp
      $error("a long response needs four response words");
   end

   logic [BLK_SZ_W-1:0]    size_q;
   logic [BLK_CNT_W-1:0]   cnt_q;
   logic [31:0]            arg_q;
   logic [31:0]            cwd_q;
   logic [31:0]            irq_mask;
   logic                   start_q;
   logic                   accept;
   logic                   cmd_inh;
   logic                   dat_inh;
   logic [31:0]            irq_word;
   logic [RSP_REGS*32-1:0] rsp_q;
   logic                   wr_cmd;
   logic                   wr_irq;

   assign wr_cmd = bus_wr_en && (bus_addr == A_CMD);
   assign wr_irq = bus_wr_en && (bus_addr == A_IRQ);

   sdh_inhibit_track u_inh (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_cmd       (wr_cmd),
      .wr_rsp       (bus_wdata[CW_RSP_LSB +: 2]),
      .wr_data_flag (bus_wdata[CW_DATA_BIT]),
      .eng_cmd_done (eng_cmd_done),
      .eng_err_any  (|eng_err),
      .eng_busy_rel (eng_busy_rel),
      .eng_data_done(eng_data_done),
      .accept       (accept),
      .cmd_inh      (cmd_inh),
      .dat_inh      (dat_inh)
   );

   sdh_irq_status #(.ERR_BITS(ERR_BITS)) u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev_cmd_done (eng_cmd_done),
      .ev_data_done(eng_data_done),
      .ev_wr_rdy   (eng_wr_rdy),
      .ev_rd_rdy   (eng_rd_rdy),
      .ev_err      (eng_err),
      .clr_wr      (wr_irq),
      .clr_ev      ({bus_wdata[IRQ_RD_RDY], bus_wdata[IRQ_WR_RDY],
                     bus_wdata[IRQ_DATA_DONE], bus_wdata[IRQ_CMD_DONE]}),
      .clr_err     (bus_wdata[IRQ_ERR_LSB +: ERR_BITS]),
      .stat_word   (irq_word)
   );

   sdh_rsp_bank #(.RSP_REGS(RSP_REGS)) u_rsp (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (eng_cmd_done),
      .rsp_type(cwd_q[CW_RSP_LSB +: 2]),
      .rsp_in  (eng_rsp),
      .rsp_q   (rsp_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q   <= '0;
         cnt_q    <= '0;
         arg_q    <= '0;
         cwd_q    <= '0;
         irq_mask <= '0;
         start_q  <= 1'b0;
      end else begin
         start_q <= accept;
         if (accept)
            cwd_q <= bus_wdata;
         if (bus_wr_en && bus_addr == A_BLK) begin
            size_q <= bus_wdata[BLK_SZ_W-1:0];
            cnt_q  <= bus_wdata[BLK_CNT_LSB +: BLK_CNT_W];
         end
         if (bus_wr_en && bus_addr == A_ARG)
            arg_q <= bus_wdata;
         if (bus_wr_en && bus_addr == A_MASK)
            irq_mask <= bus_wdata;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_BLK: begin
            bus_rdata[BLK_SZ_W-1:0]              = size_q;
            bus_rdata[BLK_CNT_LSB +: BLK_CNT_W]  = cnt_q;
         end
         A_ARG:    bus_rdata = arg_q;
         A_CMD:    bus_rdata = cwd_q;
         A_STATUS: bus_rdata[2:0] = {eng_dat_active, dat_inh, cmd_inh};
         A_IRQ:    bus_rdata = irq_word;
         A_MASK:   bus_rdata = irq_mask;
         default: begin
            for (int i = 0; i < RSP_REGS; i++)
               if (bus_addr == ADDR_W'(REG_RSP0 + i))
                  bus_rdata = rsp_q[i*32 +: 32];
         end
      endcase
   end

   assign irq              = |(irq_word & irq_mask);
   assign cmd_start        = start_q;
   assign cmd_index        = cwd_q[CW_IDX_LSB +: 6];
   assign cmd_arg          = arg_q;
   assign cmd_rsp_type     = cwd_q[CW_RSP_LSB +: 2];
   assign cmd_has_data     = cwd_q[CW_DATA_BIT];
   assign cmd_card_to_host = cwd_q[CW_DIR];
   assign cmd_multi_blk    = cwd_q[CW_MULTI];
   assign cmd_cnt_en       = cwd_q[CW_CNTEN];
   assign xfer_blk_size    = size_q;
   assign xfer_blk_cnt     = cnt_q;
endmodule

// File: rtl/sdh_cmd_issue_chk.sv
module sdh_cmd_issue_chk #(
   parameter int ADDR_W   = 4,
   parameter int ERR_BITS = 9
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr_en,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [31:0]         bus_wdata,
   input logic                eng_cmd_done,
   input logic [ERR_BITS-1:0] eng_err,
   input logic                cmd_start,
   input logic [1:0]          cmd_rsp_type,
   input logic                cmd_inh,
   input logic                dat_inh,
   input logic [31:0]         irq_word,
   input logic [31:0]         irq_mask,
   input logic                irq
);
   import sdh_cmd_pkg::*;

   // R1: a start is a single-cycle pulse
   p_start_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> !cmd_start);

   // R2: a start only follows an idle command path, and leaves it inhibited
   p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> ($past(!cmd_inh) && cmd_inh));

   // R3: busy command only issued with a free data path
   p_busy_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && cmd_rsp_type == RSP_48B) |-> $past(!dat_inh));

   // R4: busy command holds the data inhibit
   p_busy_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && cmd_rsp_type == RSP_48B) |-> dat_inh);

   // R7: write-one clears command done when no new completion arrives
   p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && bus_addr == ADDR_W'(REG_IRQ) && bus_wdata[IRQ_CMD_DONE]
       && !eng_cmd_done) |=> !irq_word[IRQ_CMD_DONE]);

   // R8: any error sets the summary bit
   p_err_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|eng_err) |=> irq_word[IRQ_ERR_SUM]);

   // R9: nothing passes a zero mask
   p_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mask == 32'd0) |-> !irq);

   // R11: completion without a new write frees the command path
   p_inh_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_cmd_done && !bus_wr_en) |=> !cmd_inh);
endmodule

bind sdh_cmd_issue sdh_cmd_issue_chk #(.ADDR_W(ADDR_W), .ERR_BITS(ERR_BITS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr_en   (bus_wr_en),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .eng_cmd_done(eng_cmd_done),
   .eng_err     (eng_err),
   .cmd_start   (cmd_start),
   .cmd_rsp_type(cmd_rsp_type),
   .cmd_inh     (cmd_inh),
   .dat_inh     (dat_inh),
   .irq_word    (irq_word),
   .irq_mask    (irq_mask),
   .irq         (irq)
);

// File: tb/sdh_cmd_issue_tb_top.sv
module sdh_cmd_issue_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr_en = 1'b0;
   logic [3:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic         irq;
   logic         cmd_start;
   logic [5:0]   cmd_index;
   logic [31:0]  cmd_arg;
   logic [1:0]   cmd_rsp_type;
   logic         cmd_has_data, cmd_card_to_host, cmd_multi_blk, cmd_cnt_en;
   logic [9:0]   xfer_blk_size;
   logic [15:0]  xfer_blk_cnt;
   logic         eng_cmd_done = 1'b0;
   logic [127:0] eng_rsp = '0;
   logic [8:0]   eng_err = '0;
   logic         eng_data_done = 1'b0, eng_wr_rdy = 1'b0, eng_rd_rdy = 1'b0;
   logic         eng_busy_rel = 1'b0, eng_dat_active = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   // bench model
   logic [31:0] m_resp [4];
   logic [3:0]  m_ev;
   logic [8:0]  m_err;
   logic        m_cinh, m_dinh;
   logic [31:0] m_mask;

   always #5 clk = ~clk;

   sdh_cmd_issue dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .cmd_start(cmd_start), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
      .cmd_rsp_type(cmd_rsp_type), .cmd_has_data(cmd_has_data),
      .cmd_card_to_host(cmd_card_to_host), .cmd_multi_blk(cmd_multi_blk),
      .cmd_cnt_en(cmd_cnt_en), .xfer_blk_size(xfer_blk_size),
      .xfer_blk_cnt(xfer_blk_cnt), .eng_cmd_done(eng_cmd_done),
      .eng_rsp(eng_rsp), .eng_err(eng_err), .eng_data_done(eng_data_done),
      .eng_wr_rdy(eng_wr_rdy), .eng_rd_rdy(eng_rd_rdy),
      .eng_busy_rel(eng_busy_rel), .eng_dat_active(eng_dat_active)
   );

   function automatic logic [31:0] exp_stat();
      logic [31:0] w = '0;
      w[0] = m_ev[0]; w[1] = m_ev[1]; w[4] = m_ev[2]; w[5] = m_ev[3];
      w[15] = |m_err;
      w[24:16] = m_err;
      return w;
   endfunction

   function automatic logic [31:0] mk_cmd(input int idx, input int rt,
                                          input bit dflag, input bit dir);
      return (32'(idx) << 24) | (32'(dflag) << 21) | (32'(rt) << 16) | (32'(dir) << 4);
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [31:0] data);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = 4'(addr); bus_wdata = data;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input int addr, output logic [31:0] data);
      bus_addr = 4'(addr);
      #1;
      data = bus_rdata;
   endtask

   task automatic rd_chk(input string req, input int addr, input logic [31:0] exp);
      logic [31:0] d;
      rd(addr, d);
      check(req, d, exp);
   endtask

   task automatic pulse_done(input logic [127:0] r, input int rt);
      @(negedge clk);
      eng_cmd_done = 1'b1; eng_rsp = r;
      @(negedge clk);
      eng_cmd_done = 1'b0;
      m_ev[0] = 1'b1; m_cinh = 1'b0;
      if (rt != 0) m_resp[0] = r[31:0];
      if (rt == 1) for (int i = 1; i < 4; i++) m_resp[i] = r[i*32 +: 32];
   endtask

   task automatic pulse_err(input logic [8:0] e);
      @(negedge clk);
      eng_err = e;
      @(negedge clk);
      eng_err = '0;
      m_err |= e; m_cinh = 1'b0;
   endtask

   task automatic pulse_busy_rel();
      @(negedge clk);
      eng_busy_rel = 1'b1;
      @(negedge clk);
      eng_busy_rel = 1'b0;
      m_dinh = 1'b0;
   endtask

   task automatic check_status(input string req);
      rd_chk(req, 7, {29'd0, 1'b0, m_dinh, m_cinh});
   endtask

   // issue a command expected to be accepted; checks the start pulse fields
   task automatic issue(input string req, input int idx, input int rt,
                        input bit dflag, input bit dir, input logic [31:0] arg);
      wr(1, arg);
      wr(2, mk_cmd(idx, rt, dflag, dir));
      check({req, " start"}, {31'd0, cmd_start}, 32'd1);
      check({req, " index"}, {26'd0, cmd_index}, 32'(idx));
      check({req, " arg"}, cmd_arg, arg);
      check({req, " type"}, {30'd0, cmd_rsp_type}, 32'(rt));
      check({req, " dir"}, {31'd0, cmd_card_to_host}, {31'd0, dir});
      m_cinh = 1'b1;
      if (rt == 3 || dflag) m_dinh = 1'b1;
      @(negedge clk);
      check("R1 pulse width", {31'd0, cmd_start}, 32'd0);
   endtask

   initial begin
      logic [31:0] d;
      void'($urandom(32'd1234));
      for (int i = 0; i < 4; i++) m_resp[i] = '0;
      m_ev = '0; m_err = '0; m_cinh = 0; m_dinh = 0; m_mask = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: reset state
      for (int a = 0; a < 10; a++) rd_chk("R12 reset reg", a, 32'd0);
      check("R12 irq", {31'd0, irq}, 32'd0);

      // R10: geometry register
      wr(0, 32'h0123_FE00);
      rd_chk("R10 readback", 0, 32'h0123_0200);
      check("R10 size out", {22'd0, xfer_blk_size}, 32'h200);
      check("R10 cnt out", {16'd0, xfer_blk_cnt}, 32'h0123);

      // R1/R2: second command while inhibited is ignored
      issue("R1 first", 17, 2, 1'b0, 1'b1, 32'hDEAD_BEEF);
      check_status("R2 cmd inhibit set");
      wr(2, mk_cmd(9, 2, 1'b0, 1'b0));
      check("R2 ignored start", {31'd0, cmd_start}, 32'd0);
      rd_chk("R2 word kept", 2, mk_cmd(17, 2, 1'b0, 1'b1));
      pulse_done(128'h4444_3333_2222_1111_0000_0000_CAFE_F00D, 2);
      // R6: only word 0 loaded
      rd_chk("R6 rsp0", 3, 32'hCAFE_F00D);
      rd_chk("R6 rsp1 kept", 4, 32'd0);
      // R11
      check_status("R11 cmd inhibit cleared by done");
      wr(8, 32'hFFFF_FFFF); m_ev = '0;

      // R3/R4: busy command gating
      issue("R4 busy cmd", 7, 3, 1'b0, 1'b0, 32'h0001_0000);
      pulse_done({4{32'h0000_0900}}, 3);
      check_status("R4 data inhibit held");
      wr(2, mk_cmd(13, 3, 1'b0, 1'b0));
      check("R3 busy blocked", {31'd0, cmd_start}, 32'd0);
      issue("R3 non-busy allowed", 13, 2, 1'b0, 1'b0, 32'h5);
      pulse_done(128'h0, 2);
      pulse_busy_rel();
      check_status("R4 busy release");
      eng_dat_active = 1'b1;
      rd_chk("R4 dat active", 7, 32'd4);
      eng_dat_active = 1'b0;
      // R4: data-present flag sets data inhibit, data done clears
      issue("R4 data cmd", 17, 2, 1'b1, 1'b1, 32'h0);
      pulse_done(128'h0, 2);
      check_status("R4 data inhibit by flag");
      @(negedge clk); eng_data_done = 1'b1;
      @(negedge clk); eng_data_done = 1'b0; m_dinh = 0; m_ev[1] = 1;
      check_status("R4 data done release");

      // R7: event bits and partial clear
      @(negedge clk); eng_wr_rdy = 1; eng_rd_rdy = 1;
      @(negedge clk); eng_wr_rdy = 0; eng_rd_rdy = 0; m_ev[2] = 1; m_ev[3] = 1;
      rd_chk("R7 events", 8, exp_stat());
      wr(8, 32'h0000_0010); m_ev[2] = 0;
      rd_chk("R7 partial clear", 8, exp_stat());
      wr(8, 32'hFFFF_FFFF); m_ev = '0;
      rd_chk("R7 all clear", 8, 32'd0);

      // R8: summary bit
      issue("R8 cmd", 2, 1, 1'b0, 1'b0, 32'h0);
      pulse_err(9'h004);
      rd_chk("R8 err set", 8, 32'h0004_8000);
      check_status("R11 cmd inhibit cleared by error");
      wr(8, 32'h0000_8000);
      rd_chk("R8 summary write ignored", 8, 32'h0004_8000);
      wr(8, 32'h0004_0000); m_err = '0;
      rd_chk("R8 summary drops", 8, 32'd0);

      // R9: mask
      @(negedge clk); eng_rd_rdy = 1;
      @(negedge clk); eng_rd_rdy = 0; m_ev[3] = 1;
      check("R9 zero mask", {31'd0, irq}, 32'd0);
      wr(9, 32'h0000_0020);
      check("R9 mask hit", {31'd0, irq}, 32'd1);
      wr(9, 32'h0000_0001);
      check("R9 mask miss", {31'd0, irq}, 32'd0);
      wr(8, 32'hFFFF_FFFF); m_ev = '0;

      // random commands
      for (int it = 0; it < 150; it++) begin
         int idx, rt;
         bit dflag, dir;
         logic [31:0] arg;
         idx = int'($urandom % 64); rt = int'($urandom % 4);
         dflag = 1'($urandom); dir = 1'($urandom); arg = $urandom;
         issue("R1 random", idx, rt, dflag, dir, arg);
         check_status("R2 random inhibit");
         if ($urandom % 4 == 0)
            pulse_err(9'(($urandom % 511) + 1));
         else
            pulse_done({$urandom, $urandom, $urandom, $urandom}, rt);
         check_status("R11 random release");
         for (int i = 0; i < 4; i++) rd_chk(i == 0 ? "R6 random rsp0" : "R5 random rsp", 3 + i, m_resp[i]);
         rd_chk("R8 random irq word", 8, exp_stat());
         m_mask = $urandom;
         wr(9, m_mask);
         check("R9 random irq", {31'd0, irq}, {31'd0, |(exp_stat() & m_mask)});
         if (m_dinh) pulse_busy_rel();
         wr(8, 32'hFFFF_FFFF); m_ev = '0; m_err = '0;
         rd_chk("R7 random clear", 8, 32'd0);
      end

      // R5: directed long response
      issue("R5 long", 2, 1, 1'b0, 1'b0, 32'h0);
      pulse_done(128'hA3A3A3A3_A2A2A2A2_A1A1A1A1_A0A0A0A0, 1);
      for (int i = 0; i < 4; i++) rd_chk("R5 long rsp", 3 + i, m_resp[i]);
      // R6: no-response command changes nothing
      issue("R6 none", 0, 0, 1'b0, 1'b0, 32'h0);
      pulse_done(128'h0, 0);
      for (int i = 0; i < 4; i++) rd_chk("R6 none keeps rsp", 3 + i, 32'hA0A0A0A0 + 32'(i) * 32'h01010101);

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule